// File: doc/BRIEF.md
# Write-Triggered Page Select Latch

This block sits between a CPU bus and a byte-wide, read-only ROM port whose internal address counter steps on each data access. The ROM cannot take data writes, so the block uses that spare operation as a bank-switch command. When the port is selected and the CPU issues a data write, the byte on the bus becomes the current page number. The page forms the upper eight bits of a 21-bit mapped address, and the ROM's 13-bit counter forms the lower bits. This gives 256 pages of 8 KiB, or 2 MiB in total.

A build-time parameter sets how the ROM port sees the bank-switch cycle. In forwarding mode the ROM port receives the write like any other access, so its counter advances by one. In isolating mode the block withholds the select, strobe and data from the ROM port for that one cycle and answers ready to the CPU itself, so the counter does not move. The clock is never gated in either mode. A second parameter adds a guard: a data write counts as a page command only while the ROM counter holds 0x1FFF. At any other address the write is passed on as an ordinary write.

Top module: `page_select_latch`

## Requirements
- R1: A cycle is a page command when `cpu_sel`, `cpu_strobe` are high and `cpu_read` = 0, `cpu_areg` = 0 (data write), subject to R8.
- R2: On a page command the full byte `cpu_wdata` (0 to 255) is stored as the page, visible on `page_o` from the cycle after the command.
- R3: After a clock edge with `rst_n` low, the page is 0.
- R4: `mapped_addr` equals `{page_o, rom_addr}`: bits 20:13 are the page and bits 12:0 are the ROM counter.
- R5: Data reads, address reads (`cpu_read`=1,`cpu_areg`=1), address writes (`cpu_read`=0,`cpu_areg`=1), idle cycles and unselected cycles leave the page unchanged. They are passed to the ROM port unaltered, and `cpu_ready` follows `rom_ready`.
- R6: With ISOLATE=0, a page command is also passed to the ROM port (`rom_sel`, `rom_strobe` high), and `cpu_ready` follows `rom_ready`.
- R7: With ISOLATE=1, during a page command `rom_sel` and `rom_strobe` are low, `rom_wdata` is 0 and `cpu_ready` is 1 whatever `rom_ready` is. The ROM counter therefore does not advance.
- R8: With GUARD_EN=1, a data write is a page command only when `rom_addr` equals 0x1FFF. Otherwise the page is unchanged and the write goes to the ROM port as in R5.
- R9: During the command cycle itself `mapped_addr[20:13]` still shows the old page. The new page appears only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Port select from the CPU side |
| cpu_strobe | input | 1 | One-cycle access strobe |
| cpu_read | input | 1 | 1 = read, 0 = write |
| cpu_areg | input | 1 | 1 = address register, 0 = data |
| cpu_wdata | input | 8 | Write byte from the CPU |
| cpu_ready | output | 1 | Ready returned to the CPU |
| rom_sel | output | 1 | Select towards the ROM port |
| rom_strobe | output | 1 | Strobe towards the ROM port |
| rom_read | output | 1 | Read/write towards the ROM port |
| rom_areg | output | 1 | Address/data towards the ROM port |
| rom_wdata | output | 8 | Write byte towards the ROM port |
| rom_ready | input | 1 | Ready from the ROM port |
| rom_addr | input | 13 | Current ROM address counter |
| page_o | output | 8 | Current page |
| mapped_addr | output | 21 | Page plus ROM counter |

## Verification
Two builds are exercised side by side: forwarding without the guard, and isolating with the guard. The two builds react differently to the same data write, which separates R6 from R7. Both are driven through all four operation codes, and unselected and idle cycles are mixed in, to show that only a selected data write alters the page. The page bytes 0x00, 0xFF and alternating patterns show that all eight bits are captured. For the guarded build, data writes are sent both at 0x1FFF and at other counter values, which separates a command from an ordinary write. With `rom_ready` held low, the block's own ready can be told apart from the ROM's ready. A stretch of random traffic then follows a model ROM counter and checks it against both builds.

// File: rtl/psl_pkg.sv
// Package: shared widths, operation codes and the bus request record for the
// page select latch. Assumes byte-wide transfers.
package psl_pkg;
    localparam int DATA_W = 8;

    // Operation code = {read, areg}
    typedef enum logic [1:0] {
        OP_WR_DATA = 2'b00,
        OP_WR_AREG = 2'b01,
        OP_RD_DATA = 2'b10,
        OP_RD_AREG = 2'b11
    } psl_op_e;

    typedef struct packed {
        logic              sel;
        logic              strobe;
        psl_op_e           op;
        logic [DATA_W-1:0] wdata;
    } psl_req_t;
endpackage

// File: rtl/psl_decode.sv
// Module: psl_decode
// Classifies the current CPU cycle and flags a page command. When the guard
// is built in, a command additionally needs the ROM counter at GUARD_ADDR.
// Assumes the request is stable for the whole strobe cycle.
module psl_decode
    import psl_pkg::*;
#(
    parameter int              OFFS_W     = 13,
    parameter bit              GUARD_EN   = 1'b0,
    parameter logic [OFFS_W-1:0] GUARD_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  psl_req_t          req,
    input  logic [OFFS_W-1:0] rom_addr,
    output logic              page_cmd
);
    logic is_wr_data;
    logic guard_ok;

    // Purpose: spot a selected, strobed data write
    always_comb begin
        is_wr_data = req.sel && req.strobe && (req.op == OP_WR_DATA);
    end

    generate
        if (GUARD_EN) begin : g_guard
            // Purpose: accept only at the guard address
            always_comb guard_ok = (rom_addr == GUARD_ADDR);

            // R8: a command never leaves the decoder off the guard address
            assert_guard_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (rom_addr != GUARD_ADDR) |-> !page_cmd);
        end else begin : g_noguard
            // Purpose: no address restriction
            always_comb guard_ok = 1'b1;
        end
    endgenerate

    // Purpose: combine write detection with the guard
    always_comb page_cmd = is_wr_data && guard_ok;

    // R1, R5: any other operation code never produces a command
    assert_other_ops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req.op != OP_WR_DATA) |-> !page_cmd);
endmodule

// File: rtl/psl_page_reg.sv
// Module: psl_page_reg
// Holds the current page. Loads the low PAGE_W bits of the write byte on a
// command and clears on reset. Assumes PAGE_W <= DATA_W.
module psl_page_reg
    import psl_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    // Purpose: synchronous reset, load on command, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (load) begin
            page <= din[PAGE_W-1:0];
        end
    end

    // R2: the byte of a command is the page one cycle later
    assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (page == $past(din[PAGE_W-1:0])));

    // R5: without a command the page holds
    assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page));

    // R3: reset clears the page
    assert_page_reset_R3: assert property (@(posedge clk)
        !rst_n |=> (page == '0));
endmodule

// File: rtl/psl_path.sv
// Module: psl_path
// Carries the CPU request to the ROM port and returns ready. In isolating
// builds it hides a page command from the ROM port and answers ready itself.
// The ROM clock is never touched here.
module psl_path
    import psl_pkg::*;
#(
    parameter bit ISOLATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  psl_req_t          req,
    input  logic              page_cmd,
    input  logic              rom_ready,
    output psl_req_t          rom_req,
    output logic              cpu_ready
);
    logic hide;

    generate
        if (ISOLATE) begin : g_isolate
            // Purpose: hide exactly the command cycles
            always_comb hide = page_cmd;

            // R7: a command never reaches the ROM port and is answered locally
            assert_hide_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
                page_cmd |-> (!rom_req.sel && !rom_req.strobe && cpu_ready
                              && (rom_req.wdata == '0)));
        end else begin : g_forward
            // Purpose: never hide anything
            always_comb hide = 1'b0;

            // R6: a command is seen by the ROM port and ready comes from it
            assert_fwd_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
                page_cmd |-> (rom_req.sel && rom_req.strobe
                              && (cpu_ready == rom_ready)));
        end
    endgenerate

    // Purpose: gate select, strobe and data while hidden
    always_comb begin
        rom_req        = req;
        if (hide) begin
            rom_req.sel    = 1'b0;
            rom_req.strobe = 1'b0;
            rom_req.wdata  = '0;
        end
    end

    // Purpose: local ready while hidden, otherwise the ROM's ready
    always_comb cpu_ready = hide ? 1'b1 : rom_ready;

    // R5: ordinary cycles reach the ROM port unchanged
    assert_pass_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !page_cmd |-> ((rom_req == req) && (cpu_ready == rom_ready)));
endmodule

// File: rtl/page_select_latch.sv
// Module: page_select_latch (top)
// Turns a selected data write on a read-only ROM port into a page select.
// The mapped address joins the page with the ROM counter. ISOLATE picks
// whether the ROM port sees the command; GUARD_EN restricts commands to
// GUARD_ADDR. Assumes one strobe per access and a synchronous ROM counter.
module page_select_latch
    import psl_pkg::*;
#(
    parameter int                PAGE_W     = 8,
    parameter int                OFFS_W     = 13,
    parameter bit                ISOLATE    = 1'b0,
    parameter bit                GUARD_EN   = 1'b0,
    parameter logic [OFFS_W-1:0] GUARD_ADDR = '1,
    localparam int               MAP_W      = PAGE_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_strobe,
    input  logic              cpu_read,
    input  logic              cpu_areg,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              rom_sel,
    output logic              rom_strobe,
    output logic              rom_read,
    output logic              rom_areg,
    output logic [DATA_W-1:0] rom_wdata,
    input  logic              rom_ready,
    input  logic [OFFS_W-1:0] rom_addr,
    output logic [PAGE_W-1:0] page_o,
    output logic [MAP_W-1:0]  mapped_addr
);
    psl_req_t cpu_req;
    psl_req_t rom_req;
    logic     page_cmd;

    // Purpose: gather CPU pins into one request record
    always_comb begin
        cpu_req.sel    = cpu_sel;
        cpu_req.strobe = cpu_strobe;
        cpu_req.op     = psl_op_e'({cpu_read, cpu_areg});
        cpu_req.wdata  = cpu_wdata;
    end

    psl_decode #(
        .OFFS_W    (OFFS_W),
        .GUARD_EN  (GUARD_EN),
        .GUARD_ADDR(GUARD_ADDR)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cpu_req),
        .rom_addr(rom_addr),
        .page_cmd(page_cmd)
    );

    psl_page_reg #(
        .PAGE_W(PAGE_W)
    ) u_page (
        .clk  (clk),
        .rst_n(rst_n),
        .load (page_cmd),
        .din  (cpu_wdata),
        .page (page_o)
    );

    psl_path #(
        .ISOLATE(ISOLATE)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cpu_req),
        .page_cmd (page_cmd),
        .rom_ready(rom_ready),
        .rom_req  (rom_req),
        .cpu_ready(cpu_ready)
    );

    // Purpose: spread the ROM-side record onto the output pins
    always_comb begin
        rom_sel    = rom_req.sel;
        rom_strobe = rom_req.strobe;
        rom_read   = rom_req.op[1];
        rom_areg   = rom_req.op[0];
        rom_wdata  = rom_req.wdata;
    end

    // Purpose: page above the ROM counter
    always_comb mapped_addr = {page_o, rom_addr};

    // R9: the mapped upper bits change only in the cycle after a command
    assert_switch_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(page_cmd)
        |-> (mapped_addr[MAP_W-1:OFFS_W] == $past(cpu_wdata[PAGE_W-1:0])));

    // R4: the low part of the mapped address is the ROM counter
    assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mapped_addr[OFFS_W-1:0] == rom_addr);
endmodule

// File: tb/test_page_select_latch.sv
// Bench: two builds (forwarding, isolating+guard) driven together and
// compared every cycle against a behavioural model with its own ROM counter.
module test_page_select_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, stb = 1'b0, rd = 1'b1, ar = 1'b0;
    logic [7:0] wd = 8'h00;
    logic       rrdy = 1'b1;
    logic [12:0] ra [2];

    logic        c_rdy [2], r_sel [2], r_stb [2], r_rd [2], r_ar [2];
    logic [7:0]  r_wd [2], pg [2];
    logic [20:0] map [2];

    int checks = 0;
    int errors = 0;
    int page_m [2];
    int cnt_m  [2];
    bit iso [2] = '{1'b0, 1'b1};
    bit grd [2] = '{1'b0, 1'b1};

    always #4 clk = ~clk;

    page_select_latch #(.ISOLATE(1'b0), .GUARD_EN(1'b0)) i_page_select_latch (
        .clk(clk), .rst_n(rst_n), .cpu_sel(sel), .cpu_strobe(stb),
        .cpu_read(rd), .cpu_areg(ar), .cpu_wdata(wd), .cpu_ready(c_rdy[0]),
        .rom_sel(r_sel[0]), .rom_strobe(r_stb[0]), .rom_read(r_rd[0]),
        .rom_areg(r_ar[0]), .rom_wdata(r_wd[0]), .rom_ready(rrdy),
        .rom_addr(ra[0]), .page_o(pg[0]), .mapped_addr(map[0]));

    page_select_latch #(.ISOLATE(1'b1), .GUARD_EN(1'b1)) i_page_select_latch_iso (
        .clk(clk), .rst_n(rst_n), .cpu_sel(sel), .cpu_strobe(stb),
        .cpu_read(rd), .cpu_areg(ar), .cpu_wdata(wd), .cpu_ready(c_rdy[1]),
        .rom_sel(r_sel[1]), .rom_strobe(r_stb[1]), .rom_read(r_rd[1]),
        .rom_areg(r_ar[1]), .rom_wdata(r_wd[1]), .rom_ready(rrdy),
        .rom_addr(ra[1]), .page_o(pg[1]), .mapped_addr(map[1]));

    task automatic chk(input string req, input int k, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s build%0d: actual %0h expected %0h", req, k, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One bus cycle: drive, compare, clock, update model
    task automatic cyc(input bit s, input bit t, input bit r, input bit a,
                       input logic [7:0] d, input bit rdy);
        bit cmd [2];
        bit fwd [2];
        @(negedge clk);
        sel = s; stb = t; rd = r; ar = a; wd = d; rrdy = rdy;
        #1;
        for (int k = 0; k < 2; k++) begin
            cmd[k] = s && t && !r && !a && (!grd[k] || cnt_m[k] == 13'h1FFF);
            fwd[k] = !(iso[k] && cmd[k]);
            chk("R2", k, pg[k], page_m[k]);
            chk("R4", k, map[k], (page_m[k] << 13) | cnt_m[k]);
            chk("R9", k, map[k][20:13], page_m[k]);
            if (fwd[k]) begin
                chk(cmd[k] ? "R6" : "R5", k, {r_sel[k], r_stb[k], r_rd[k], r_ar[k], r_wd[k], c_rdy[k]},
                    {s, t, r, a, d, rdy});
            end else begin
                chk("R7", k, {r_sel[k], r_stb[k], r_wd[k], c_rdy[k]}, {1'b0, 1'b0, 8'h00, 1'b1});
            end
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            if (cmd[k]) page_m[k] = d;
            if (fwd[k] && s && t && !a) cnt_m[k] = (cnt_m[k] + 1) % 8192;
            ra[k] = 13'(cnt_m[k]);
        end
    endtask

    task automatic set_cnt(input int k, input int v);
        cnt_m[k] = v;
        ra[k] = 13'(v);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            page_m[k] = 0;
            set_cnt(k, 0);
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R3: page is zero after reset
        for (int k = 0; k < 2; k++) chk("R3", k, pg[k], 0);

        // R1, R6, R8: data write off the guard address
        set_cnt(1, 13'h0010);
        cyc(1, 1, 0, 0, 8'h5A, 1);
        cyc(1, 1, 1, 0, 8'h00, 1);
        // R7, R8: at the guard address, ROM not ready
        set_cnt(1, 13'h1FFF);
        cyc(1, 1, 0, 0, 8'hA5, 0);
        cyc(1, 1, 1, 0, 8'h00, 1);
        // R5: other operations and unselected writes
        cyc(1, 1, 1, 1, 8'hFF, 1);
        cyc(1, 1, 0, 1, 8'hFF, 1);
        cyc(0, 1, 0, 0, 8'h33, 1);
        cyc(1, 0, 0, 0, 8'h44, 1);
        // R2 boundaries; R6 with ROM stalled
        set_cnt(1, 13'h1FFF);
        cyc(1, 1, 0, 0, 8'hFF, 0);
        set_cnt(1, 13'h1FFF);
        cyc(1, 1, 0, 0, 8'h00, 1);
        cyc(1, 1, 1, 0, 8'h00, 1);
        // random traffic; occasional jumps to the guard address
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) set_cnt(1, 13'h1FFF);
            cyc($urandom_range(0, 5) != 0, $urandom_range(0, 4) != 0,
                $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                8'($urandom), $urandom_range(0, 3) != 0);
        end
        // R3: reset in mid-run clears the page
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            page_m[k] = 0;
            chk("R3", k, pg[k], 0);
        end
        summary();
    end
endmodule